// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block tracks the single reservation a hart holds for atomic read-modify-write sequences built from a load-reserved followed by a store-conditional. A load-reserved arms the reservation and stores the word address it touched. A later store-conditional succeeds only while that reservation is still armed and names the same word. On success the store is allowed and the result code is zero. In every other case the store is blocked and the result code is one.

Writes by other harts are reported on a snoop port. A snoop that lands on the reserved word disarms the reservation, so a competing hart's increment cannot be lost. The losing hart sees a nonzero code and runs its load-reserved / store-conditional loop again.

The store enable and the result code are combinational in the request cycle, so the pipeline can commit the store in that same cycle. Reservation state changes take effect at the next rising clock edge.

Top module: `lrsc_monitor`

## Requirements
- R1: A store-conditional issued while no reservation is armed (for example straight after reset) reports code 1 and keeps the store enable low.
- R2: A store-conditional to a word other than the reserved one (for example 1024 bytes away) reports code 1 and keeps the store enable low.
- R3: A store-conditional to the reserved word, while the reservation is armed, raises the store enable and reports code 0 in the same cycle as the request.
- R4: A load-reserved arms the reservation on its word. A newer load-reserved replaces an older one, so a store-conditional to the older word then fails.
- R5: Every store-conditional disarms the reservation, whether it succeeds or fails, so a second store-conditional without a new load-reserved fails.
- R6: A snoop write to the reserved word disarms the reservation. A snoop write to any other word leaves it armed.
- R7: Address comparison is at word granularity: the lowest two address bits are ignored, both for store-conditionals and for snoops.
- R8: A snoop to the reserved word in the same cycle as a store-conditional to that word makes the store-conditional fail.
- R9: Reset disarms the reservation.
- R10: Request kind encoding is 2'b00 idle, 2'b01 load-reserved, 2'b10 store-conditional and 2'b11 other access. Kinds 2'b00 and 2'b11 leave the reservation unchanged. The done strobe is high only in a store-conditional cycle, and the code is 0 whenever done is low.
- R11: A load-reserved and a snoop to the same word in the same cycle leave the reservation armed, because the load is taken as ordered after the foreign write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request from this hart is present |
| reqKind | input | 2 | Request kind (see R10) |
| reqAddr | input | ADDR_W | Byte address of the request |
| snoopValid | input | 1 | Another agent writes this cycle |
| snoopAddr | input | ADDR_W | Byte address of the foreign write |
| storeEn | output | 1 | The store-conditional may write memory |
| scDone | output | 1 | A store-conditional result is presented |
| scStatus | output | STATUS_W | Result code for the destination register: 0 on success, 1 on failure |

## Verification
The store enable, done strobe and result code respond within the request cycle. The bench drives each vector on the falling edge and samples these outputs one time unit later, before the next rising edge. Reservation effects (arming, replacement, disarming by a store-conditional, a snoop or reset) appear only at the next rising edge. The bench therefore judges each of them through the store-conditional issued in a following cycle. The vector order chains these effects so that every outcome depends on the state left by the vectors before it.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_LR    = 2'b01,
    KIND_SC    = 2'b10,
    KIND_OTHER = 2'b11
  } reqKind_e;

  typedef struct packed {
    logic setResv;
    logic clrResv;
  } resvStrobe_t;

endpackage

// File: rtl/lrsc_datapath.sv
module lrsc_datapath
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAIN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              resvValid,
  output logic [ADDR_W-1:0] resvAddr,
  output logic              scMatch,
  output logic              snoopMatch
);

  localparam logic [ADDR_W-1:0] GRAIN_MASK = ~((ADDR_W'(1) << GRAIN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] reqWord;
  logic [ADDR_W-1:0] snoopWord;

  assign reqWord   = reqAddr & GRAIN_MASK;
  assign snoopWord = snoopAddr & GRAIN_MASK;

  assign scMatch    = resvValid && (reqWord == resvAddr);
  assign snoopMatch = resvValid && snoopValid && (snoopWord == resvAddr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resvValid <= 1'b0;
      resvAddr  <= '0;
    end else if (strobe.setResv) begin
      resvValid <= 1'b1;
      resvAddr  <= reqWord;
    end else if (strobe.clrResv) begin
      resvValid <= 1'b0;
    end
  end

  // R4: an armed reservation always holds a word-aligned address
  p_aligned_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resvValid |-> ((resvAddr & ~GRAIN_MASK) == '0));

endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int STATUS_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic                scMatch,
  input  logic                snoopMatch,
  output resvStrobe_t         strobe,
  output logic                storeEn,
  output logic                scDone,
  output logic [STATUS_W-1:0] scStatus
);

  reqKind_e kind;
  logic     isLr;
  logic     isSc;

  assign kind = reqKind_e'(reqKind);
  assign isLr = reqValid && (kind == KIND_LR);
  assign isSc = reqValid && (kind == KIND_SC);

  always_comb begin
    strobe.setResv = isLr;
    strobe.clrResv = isSc || snoopMatch;
    storeEn        = isSc && scMatch && !snoopMatch;
    scDone         = isSc;
    scStatus       = '0;
    if (isSc && !storeEn) scStatus = STATUS_W'(1);
  end

  // R5: two store-conditionals back to back: the second cannot write
  p_sc_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (isSc && $past(isSc)) |-> !storeEn);

  // R10: no write outside a store-conditional cycle
  p_store_only_sc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    storeEn |-> scDone);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAIN_BITS = 2,
  parameter int STATUS_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                snoopValid,
  input  logic [ADDR_W-1:0]   snoopAddr,
  output logic                storeEn,
  output logic                scDone,
  output logic [STATUS_W-1:0] scStatus
);

  resvStrobe_t       strobe;
  logic              resvValid;
  logic [ADDR_W-1:0] resvAddr;
  logic              scMatch;
  logic              snoopMatch;

  lrsc_ctrl #(.STATUS_W(STATUS_W)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .scMatch    (scMatch),
    .snoopMatch (snoopMatch),
    .strobe     (strobe),
    .storeEn    (storeEn),
    .scDone     (scDone),
    .scStatus   (scStatus)
  );

  lrsc_datapath #(.ADDR_W(ADDR_W), .GRAIN_BITS(GRAIN_BITS)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .resvValid  (resvValid),
    .resvAddr   (resvAddr),
    .scMatch    (scMatch),
    .snoopMatch (snoopMatch)
  );

  localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << GRAIN_BITS) - ADDR_W'(1));

  logic portLr;
  logic portSc;
  assign portLr = reqValid && (reqKind == 2'b01);
  assign portSc = reqValid && (reqKind == 2'b10);

  // R5: any store-conditional leaves the reservation disarmed
  p_sc_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    portSc |=> !resvValid);

  // R4: a load-reserved arms the reservation on its word
  p_lr_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    portLr |=> (resvValid && resvAddr == ($past(reqAddr) & WORD_MASK)));

  // R6: a foreign write to the reserved word disarms it
  p_snoop_kills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resvValid && snoopValid && ((snoopAddr & WORD_MASK) == resvAddr) && !portLr) |=> !resvValid);

  // R3: a write is only allowed under an armed reservation
  p_store_needs_resv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    storeEn |-> resvValid);

endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int STATUS_W   = 64;

  typedef struct packed {
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic              snp;
    logic [ADDR_W-1:0] snpAddr;
    logic              expSe;
    logic              expDone;
    logic [7:0]        req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{2'b10, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 8'd1},  // R1 no reservation yet
    '{2'b01, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4 arm 0x100
    '{2'b10, 32'h500, 1'b0, 32'h0,   1'b0, 1'b1, 8'd2},  // R2 1024 bytes away
    '{2'b10, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 8'd5},  // R5 consumed by failed SC
    '{2'b01, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4 arm 0x200
    '{2'b10, 32'h203, 1'b0, 32'h0,   1'b1, 1'b1, 8'd7},  // R7 R3 low bits ignored
    '{2'b10, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 8'd5},  // R5 consumed by success
    '{2'b01, 32'h300, 1'b1, 32'h300, 1'b0, 1'b0, 8'd11}, // R11 LR with snoop
    '{2'b00, 32'h0,   1'b1, 32'h304, 1'b0, 1'b0, 8'd6},  // R6 other word snooped
    '{2'b10, 32'h300, 1'b0, 32'h0,   1'b1, 1'b1, 8'd11}, // R11 R6 still armed
    '{2'b01, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4 arm 0x400
    '{2'b00, 32'h0,   1'b1, 32'h402, 1'b0, 1'b0, 8'd6},  // R6 R7 foreign write
    '{2'b10, 32'h400, 1'b0, 32'h0,   1'b0, 1'b1, 8'd6},  // R6 lost reservation
    '{2'b01, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 8'd6},  // R6 retry loop rearms
    '{2'b10, 32'h400, 1'b1, 32'h400, 1'b0, 1'b1, 8'd8},  // R8 same-cycle snoop
    '{2'b01, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4
    '{2'b01, 32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4 replaces 0x400
    '{2'b10, 32'h400, 1'b0, 32'h0,   1'b0, 1'b1, 8'd4},  // R4 old word fails
    '{2'b01, 32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 8'd4},  // R4
    '{2'b11, 32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 8'd10}, // R10 other kind ignored
    '{2'b10, 32'h600, 1'b0, 32'h0,   1'b1, 1'b1, 8'd10}  // R10 R3 still armed
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                reqValid = 1'b0;
  logic [1:0]          reqKind = 2'b00;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic                snoopValid = 1'b0;
  logic [ADDR_W-1:0]   snoopAddr = '0;
  logic                storeEn;
  logic                scDone;
  logic [STATUS_W-1:0] scStatus;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .storeEn(storeEn), .scDone(scDone), .scStatus(scStatus)
  );

  task automatic checkOut(input int req, input logic expSe, input logic expDone);
    logic [STATUS_W-1:0] expSt;
    expSt = (expDone && !expSe) ? STATUS_W'(1) : '0;
    nChecks++;
    if (storeEn !== expSe || scDone !== expDone || scStatus !== expSt) begin
      nFail++;
      $display("FAIL R%0d: storeEn=%0b scDone=%0b scStatus=%0h expected storeEn=%0b scDone=%0b scStatus=%0h",
               req, storeEn, scDone, scStatus, expSe, expDone, expSt);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                       input logic s, input logic [ADDR_W-1:0] sa);
    @(negedge clk);
    reqValid   = (k != 2'b00);
    reqKind    = k;
    reqAddr    = a;
    snoopValid = s;
    snoopAddr  = sa;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    // R9 reset state: SC held during reset sees no reservation
    drive(2'b10, 32'h100, 1'b0, '0);
    checkOut(9, 1'b0, 1'b1);
    drive(2'b00, 32'h0, 1'b0, '0);
    checkOut(10, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].kind, VECS[i].addr, VECS[i].snp, VECS[i].snpAddr);
      checkOut(int'(VECS[i].req), VECS[i].expSe, VECS[i].expDone);
    end

    // R9: reset disarms a live reservation
    drive(2'b01, 32'h700, 1'b0, '0);
    checkOut(9, 1'b0, 1'b0);
    drive(2'b00, 32'h0, 1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b10, 32'h700, 1'b0, '0);
    checkOut(9, 1'b0, 1'b1);

    // R1 R3: reservation rebuilt after reset works
    drive(2'b01, 32'h7FC, 1'b0, '0);
    drive(2'b10, 32'h7FE, 1'b0, '0);
    checkOut(3, 1'b1, 1'b1);

    // R10: reqValid low masks the kind
    drive(2'b01, 32'h800, 1'b0, '0);
    @(negedge clk);
    reqValid = 1'b0;
    reqKind  = 2'b10;
    reqAddr  = 32'h800;
    #1;
    checkOut(10, 1'b0, 1'b0);
    drive(2'b10, 32'h800, 1'b0, '0);
    checkOut(10, 1'b1, 1'b1);

    drive(2'b00, 32'h0, 1'b0, '0);
    summary();
  end

endmodule